// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns one burst request into the sequence of column addresses that a memory data path walks through, one address per data beat. A request is a single-cycle start pulse that carries a 9-bit starting column, a 3-bit length code and an order bit. From the following cycle the block presents one column per cycle together with a valid flag. A last flag marks the final beat of a finite burst.

Finite bursts of 2, 4 or 8 beats stay inside the aligned block of that size that holds the starting column. The address bits above the block are held, and only the low bits move. They move either by incrementing with wrap-around (sequential order) or by XOR of the starting offset with the beat number (interleave order). A full-page burst sweeps the whole 512-column row with wrap-around and runs until it is stopped. A stop input cuts any burst short, and a fresh start pulse restarts the sequence at once. A request that cannot be served raises a one-cycle error flag and is otherwise dropped.

Top module: `burst_col_gen`

## Requirements
- R1: While rst_ni is low and after it rises with no request, valid_o, last_o and err_o are 0.
- R2: A legal start pulse sampled at a clock edge makes valid_o 1 after that edge, with col_o equal to start_col_i (beat 0).
- R3: Length codes on blen_i: 3'b001 gives 2 beats, 3'b010 gives 4 beats, 3'b011 gives 8 beats. last_o is 1 exactly on the final beat, and valid_o falls on the cycle after it unless a new burst starts.
- R4: With order_i = 0 (sequential) and a finite length N, beat k shows column (start with its low log2(N) bits replaced by (start + k) mod N). For example, N = 8 from offset 5 gives offsets 5,6,7,0,1,2,3,4.
- R5: With order_i = 1 (interleave) and a finite length N, the low log2(N) bits on beat k equal the start offset XOR k, and the upper bits are held. For example, N = 8 from offset 3 gives 3,2,1,0,7,6,5,4.
- R6: Length code 3'b111 with order_i = 0 and an even start column gives a full-page burst. col_o rises by 1 modulo 512 each cycle, last_o stays 0, and the burst continues until stopped.
- R7: A start pulse with a reserved length code (3'b000, 3'b100, 3'b101, 3'b110), or with code 3'b111 together with order_i = 1 or an odd start column, sets err_o to 1 for the one cycle after that edge. It starts no burst and leaves a burst already in progress unchanged.
- R8: stop_i sampled high during a burst (without a start) makes valid_o and last_o 0 after that edge.
- R9: A legal start pulse during a burst restarts the sequence at the new column after that edge. A start in the same cycle as stop_i takes precedence over the stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse for a new burst |
| start_col_i | input | 9 | Starting column of the burst |
| blen_i | input | 3 | Burst length code |
| order_i | input | 1 | Burst order: 0 sequential, 1 interleave |
| stop_i | input | 1 | Ends the current burst |
| col_o | output | 9 | Column for the current beat |
| valid_o | output | 1 | col_o holds a burst beat |
| last_o | output | 1 | Current beat is the final beat of a finite burst |
| err_o | output | 1 | Previous start request was rejected |

## Verification
Every output is registered, so each result is due exactly one cycle after the edge that samples its cause. The first column and an error pulse appear one cycle after the start, a stop shows one cycle after it is sampled, and valid_o falls one cycle after the last beat. The driver changes inputs on the falling edge and pushes one expected item per clock. That item is worked out from the length, order and start offset. The monitor pops one item 2 ns after every rising edge, so each comparison lines up with the cycle that carries that result.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  localparam int unsigned COL_W = 9;

  typedef enum logic [2:0] {
    BLEN_2    = 3'b001,
    BLEN_4    = 3'b010,
    BLEN_8    = 3'b011,
    BLEN_PAGE = 3'b111
  } blen_e;

  typedef struct packed {
    logic             legal;
    logic             full;
    logic [COL_W-1:0] mask;
  } mode_t;
endpackage

// File: rtl/burst_mode_dec.sv
module burst_mode_dec
  import burst_col_pkg::*;
#(
  parameter int unsigned CW = COL_W
) (
  input  logic [2:0]    blen_i,
  input  logic          order_i,
  input  logic [CW-1:0] col_i,
  output logic          legal_o,
  output logic          full_o,
  output logic [CW-1:0] mask_o
);
  always_comb begin
    legal_o = 1'b1;
    full_o  = 1'b0;
    mask_o  = '0;
    unique case (blen_i)
      BLEN_2:    mask_o = CW'(1);
      BLEN_4:    mask_o = CW'(3);
      BLEN_8:    mask_o = CW'(7);
      BLEN_PAGE: begin
        full_o  = 1'b1;
        mask_o  = '1;
        // page mode is sequential-only and must start on an even column
        legal_o = ~order_i & ~col_i[0];
      end
      default:   legal_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_col_pkg::*;
#(
  parameter int unsigned CW = COL_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          stop_i,
  input  logic [CW-1:0] col_i,
  input  logic [CW-1:0] mask_i,
  input  logic          full_i,
  input  logic          order_i,
  output logic          valid_o,
  output logic          last_o,
  output logic [CW-1:0] beat_o,
  output logic [CW-1:0] base_o,
  output logic [CW-1:0] mask_o,
  output logic          order_o
);
  logic full_q;

  assign last_o = valid_o & ~full_q & (beat_o == mask_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      beat_o  <= '0;
      base_o  <= '0;
      mask_o  <= '0;
      order_o <= 1'b0;
      full_q  <= 1'b0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      beat_o  <= '0;
      base_o  <= col_i;
      mask_o  <= mask_i;
      order_o <= order_i;
      full_q  <= full_i;
    end else if (valid_o) begin
      if (stop_i || last_o) valid_o <= 1'b0;
      else                  beat_o  <= beat_o + 1'b1;
    end
  end

  // R3
  last_ends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o && !load_i |=> !valid_o);
  // R8
  stop_ends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && stop_i && !load_i |=> !valid_o);
  // R2
  load_beat0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> valid_o && beat_o == '0);
endmodule

// File: rtl/burst_addr_form.sv
module burst_addr_form
  import burst_col_pkg::*;
#(
  parameter int unsigned CW = COL_W
) (
  input  logic [CW-1:0] base_i,
  input  logic [CW-1:0] beat_i,
  input  logic [CW-1:0] mask_i,
  input  logic          order_i,
  output logic [CW-1:0] col_o
);
  logic [CW-1:0] seq_w, ilv_w, mov_w;

  assign seq_w = base_i + beat_i;
  assign ilv_w = base_i ^ beat_i;
  assign mov_w = order_i ? ilv_w : seq_w;

  // masked bits move, the rest hold the aligned block
  for (genvar b = 0; b < CW; b++) begin : g_bit
    assign col_o[b] = mask_i[b] ? mov_w[b] : base_i[b];
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int unsigned CW = COL_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] start_col_i,
  input  logic [2:0]    blen_i,
  input  logic          order_i,
  input  logic          stop_i,
  output logic [CW-1:0] col_o,
  output logic          valid_o,
  output logic          last_o,
  output logic          err_o
);
  logic          legal_w, full_w, load_w;
  logic [CW-1:0] mask_w, beat_w, base_w, mask_q;
  logic          order_q;

  burst_mode_dec #(.CW(CW)) u_dec (
    .blen_i  (blen_i),
    .order_i (order_i),
    .col_i   (start_col_i),
    .legal_o (legal_w),
    .full_o  (full_w),
    .mask_o  (mask_w)
  );

  assign load_w = start_i & legal_w;

  burst_beat_ctr #(.CW(CW)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_w),
    .stop_i  (stop_i),
    .col_i   (start_col_i),
    .mask_i  (mask_w),
    .full_i  (full_w),
    .order_i (order_i),
    .valid_o (valid_o),
    .last_o  (last_o),
    .beat_o  (beat_w),
    .base_o  (base_w),
    .mask_o  (mask_q),
    .order_o (order_q)
  );

  burst_addr_form #(.CW(CW)) u_addr (
    .base_i  (base_w),
    .beat_i  (beat_w),
    .mask_i  (mask_q),
    .order_i (order_q),
    .col_o   (col_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_o <= 1'b0;
    else         err_o <= start_i & ~legal_w;
  end

  // R7
  err_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && (blen_i == 3'b000 || blen_i[2:1] == 2'b10 || blen_i == 3'b110) |=> err_o);
  // R7
  err_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $stable(col_o) || !valid_o || $past(valid_o) && !$past(last_o));
  // R3
  last_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);
  // R2
  start_col_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && blen_i == 3'b011 |=> valid_o && col_o == $past(start_col_i));
  // R6
  page_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !last_o && mask_q == '1 && !start_i && !stop_i |=> col_o == $past(col_o) + 1'b1);
endmodule

// File: tb/burst_col_gen_tb_top.sv
module burst_col_gen_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [8:0] start_col_i = '0;
  logic [2:0] blen_i = '0;
  logic       order_i = 1'b0;
  logic       stop_i = 1'b0;
  logic [8:0] col_o;
  logic       valid_o, last_o, err_o;

  always #5 clk_i = ~clk_i;

  burst_col_gen dut_i (.*);

  typedef struct {
    logic       valid;
    logic       last;
    logic       err;
    logic [8:0] col;
    string      tag;
  } exp_t;

  exp_t q[$];
  int n_vec = 0;
  int n_bad = 0;

  // bench model state
  logic   m_act = 1'b0;
  int     m_base, m_len, m_beat;
  logic   m_ord;

  task automatic fail(string tag, string what, int act, int exp);
    n_bad++;
    $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
  endtask

  task automatic step(input logic st, input int col, input int code,
                      input logic ord, input logic sp, input string tag);
    exp_t e;
    logic legal;
    int   ln;
    @(negedge clk_i);
    start_i = st; start_col_i = col[8:0]; blen_i = code[2:0];
    order_i = ord; stop_i = sp;
    ln = (code == 1) ? 2 : (code == 2) ? 4 : (code == 3) ? 8 : 0;
    legal = (ln != 0) || (code == 7 && !ord && (col % 2 == 0));
    e.err = st && !legal;
    if (st && legal) begin
      m_act = 1'b1; m_base = col; m_len = ln; m_ord = ord; m_beat = 0;
    end else if (m_act) begin
      if (sp || (m_len != 0 && m_beat == m_len - 1)) m_act = 1'b0;
      else m_beat++;
    end
    e.valid = m_act;
    e.last  = m_act && m_len != 0 && m_beat == m_len - 1;
    if (m_len == 0) e.col = 9'((m_base + m_beat) % 512);
    else begin
      int off;
      off = m_base % m_len;
      e.col = 9'(m_base - off + (m_ord ? (off ^ m_beat) : (off + m_beat) % m_len));
    end
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 0, 0, 1'b0, 1'b0, tag);
  endtask

  // monitor: outputs settle after each rising edge
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      if (q.size() != 0) begin
        exp_t e;
        e = q.pop_front();
        n_vec++;
        if (valid_o !== e.valid) fail(e.tag, "valid", int'(valid_o), int'(e.valid));
        if (last_o !== e.last)   fail(e.tag, "last", int'(last_o), int'(e.last));
        if (err_o !== e.err)     fail(e.tag, "err", int'(err_o), int'(e.err));
        if (e.valid && col_o !== e.col) fail(e.tag, "col", int'(col_o), int'(e.col));
      end
    end
  end

  initial begin
    fork
      begin
        #23;
        n_vec++;
        if (valid_o !== 1'b0 || last_o !== 1'b0 || err_o !== 1'b0)
          fail("R1", "reset outputs", int'({valid_o, last_o, err_o}), 0);
        rst_ni = 1'b1;
        idle(2, "R1");
        // R3 R4: 8-beat sequential from offset 5
        step(1'b1, 9'h1A5, 3, 1'b0, 1'b0, "R4");
        idle(9, "R3");
        // R5: 8-beat interleave from offset 3
        step(1'b1, 9'h0C3, 3, 1'b1, 1'b0, "R5");
        idle(9, "R5");
        // R3 R4: 4-beat sequential, R5: 2- and 4-beat interleave
        step(1'b1, 9'h00E, 2, 1'b0, 1'b0, "R4");
        idle(5, "R3");
        step(1'b1, 9'h101, 1, 1'b1, 1'b0, "R5");
        idle(3, "R3");
        step(1'b1, 9'h06D, 2, 1'b1, 1'b0, "R5");
        idle(5, "R5");
        // R6: full page wraps past 511, R8 stop ends it
        step(1'b1, 9'h1FA, 7, 1'b0, 1'b0, "R6");
        idle(12, "R6");
        step(1'b0, 0, 0, 1'b0, 1'b1, "R8");
        idle(2, "R8");
        // R7: rejected requests
        step(1'b1, 9'h010, 0, 1'b0, 1'b0, "R7");
        step(1'b1, 9'h010, 4, 1'b0, 1'b0, "R7");
        step(1'b1, 9'h010, 5, 1'b1, 1'b0, "R7");
        step(1'b1, 9'h010, 6, 1'b0, 1'b0, "R7");
        step(1'b1, 9'h010, 7, 1'b1, 1'b0, "R7");
        step(1'b1, 9'h011, 7, 1'b0, 1'b0, "R7");
        idle(2, "R7");
        // R7: rejection mid-burst leaves burst running
        step(1'b1, 9'h040, 3, 1'b0, 1'b0, "R7");
        idle(2, "R7");
        step(1'b1, 9'h077, 0, 1'b0, 1'b0, "R7");
        idle(7, "R7");
        // R8: stop an 8-beat burst after three beats
        step(1'b1, 9'h082, 3, 1'b1, 1'b0, "R8");
        idle(2, "R8");
        step(1'b0, 0, 0, 1'b0, 1'b1, "R8");
        idle(2, "R8");
        // R9: restart mid-burst, then start wins over stop
        step(1'b1, 9'h120, 3, 1'b0, 1'b0, "R9");
        idle(3, "R9");
        step(1'b1, 9'h036, 2, 1'b0, 1'b0, "R9");
        idle(1, "R9");
        step(1'b1, 9'h1F0, 7, 1'b0, 1'b1, "R9");
        idle(3, "R9");
        step(1'b0, 0, 0, 1'b0, 1'b1, "R8");
        idle(3, "R1");
        wait (q.size() == 0);
        @(negedge clk_i);
      end
      begin
        repeat (100000) @(posedge clk_i);
        n_bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule